// File: doc/BRIEF.md
# SDRAM Read Latency and Burst Sequencer

This block is the device-side timing core of a single-data-rate SDRAM. It takes a command that has already been registered, a column address and a mode word. It keeps the accepted mode settings and drives the data-bus output enable, a data-valid strobe, the read data and the column of each burst beat. Data lives in a small internal array. Reads come out after a programmable latency of two or three clocks. Writes take their data in the same cycles as the beats.

The mode word selects four things: the read latency, the burst length, a write-burst mode that can force writes down to a single location, and an operating-mode field. Only the all-zero operating mode is accepted. A burst covers an aligned block of the burst length and wraps inside it. A READ issued exactly one burst after the previous one keeps the bus busy with no gap. A NOP never disturbs a burst in progress. A READ or WRITE that arrives during a burst cuts the old burst short and starts the new one.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, dq_oe_o, dq_valid_o, beat_act_o and mode_err_o are low and dq_o is zero. The mode in force is a latency of 2, a burst length of 1 and full write bursts.
- R2: Mode bits [6:4] select the latency: 010 gives 2 and 011 gives 3. For a READ (cmd_i = 01) registered at edge n, dq_valid_o goes high and the first word appears on dq_o after edge n+CL.
- R3: For that READ, dq_oe_o goes high after edge n+CL-1, one cycle before the first valid word.
- R4: Mode bits [2:0] select the burst length: 000, 001, 010 and 011 give 1, 2, 4 and 8 consecutive valid beats. Every other code gives a length of 1.
- R5: Beat k of a burst starting at column c uses column (c & ~(BL-1)) | ((c+k) mod BL). After edge n+k, beat_act_o is high and beat_col_o shows that column. Read beat k carries the word stored at that column.
- R6: With mode bit 9 at 0, a WRITE (cmd_i = 10) registered at edge n runs for BL beats. The wdata_i value present at edge n+k is stored at the column of beat k.
- R7: With mode bit 9 at 1, a WRITE stores only the word present at edge n, at column c, and beat_act_o is low after edge n+1. Reads still use the programmed burst length.
- R8: A LOAD MODE (cmd_i = 11) is rejected if bits [6:4] are neither 010 nor 011, or if bits [8:7] are not 00. A rejected load leaves the mode unchanged and sets mode_err_o after that edge. mode_err_o stays set until reset, even through later legal loads. Bit 3 is ignored.
- R9: dq_oe_o and dq_valid_o are low after edge n+CL+BL, one cycle after the last beat. A READ registered BL edges after a previous READ keeps both signals high without a break for all 2*BL beats.
- R10: A NOP (cmd_i = 00) during a burst leaves that burst untouched. col_i and mode_i carry no meaning on a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Registered command: 00 NOP, 01 READ, 10 WRITE, 11 LOAD MODE |
| col_i | input | COL_W | Start column of a READ or WRITE |
| mode_i | input | 10 | Mode word taken on LOAD MODE |
| wdata_i | input | DATA_W | Write data for the current write beat |
| dq_o | output | DATA_W | Read data, zero when not valid |
| dq_oe_o | output | 1 | Data-bus output enable |
| dq_valid_o | output | 1 | Read data valid |
| beat_act_o | output | 1 | A burst beat was issued at the last edge |
| beat_col_o | output | COL_W | Column of that beat |
| mode_err_o | output | 1 | Sticky flag for a rejected mode load |

## Verification
Each result is due a fixed number of edges after the edge that registers its command. The beat column appears after edge n+k. The output enable rises after edge n+CL-1. Valid data holds from edge n+CL through edge n+CL+BL-1, and both bus signals drop after edge n+CL+BL. The error flag updates after the load edge itself. The bench drives and samples only on falling edges and counts falling edges from the command. It compares enable, valid and data in every cycle of a burst window, including the cycle after it, so a burst that starts early, starts late or runs one beat too long is caught. Writes are checked one beat at a time on the column outputs and then again through a later read.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  localparam int MODE_W = 10;
  localparam int CL_MIN = 2;
  localparam int CL_MAX = 3;
  localparam int BL_MAX = 8;
  localparam int CNT_W  = $clog2(BL_MAX);

  // mode word field positions
  localparam int F_BL_LO = 0;
  localparam int F_CL_LO = 4;
  localparam int F_OP_LO = 7;
  localparam int F_WBM   = 9;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_LOAD  = 2'b11
  } cmd_e;

  // burst length minus one, reserved codes collapse to a single beat
  function automatic logic [CNT_W-1:0] bl_mask(input logic [2:0] code);
    case (code)
      3'd1:    return CNT_W'(1);
      3'd2:    return CNT_W'(3);
      3'd3:    return CNT_W'(7);
      default: return '0;
    endcase
  endfunction

  function automatic logic cl_legal(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction
endpackage

// File: rtl/sdseq_mode_reg.sv
module sdseq_mode_reg
  import sdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              cl3_o,
  output logic [CNT_W-1:0]  bl_mask_o,
  output logic              wbm_o,
  output logic              err_o
);
  logic             cl3_q, cl3_d;
  logic [CNT_W-1:0] msk_q, msk_d;
  logic             wbm_q, wbm_d;
  logic             err_q, err_d;
  logic             legal;

  always_comb begin
    legal = cl_legal(mode_i[F_CL_LO +: 3]) && (mode_i[F_OP_LO +: 2] == 2'b00);
    cl3_d = cl3_q;
    msk_d = msk_q;
    wbm_d = wbm_q;
    err_d = err_q;
    if (load_i) begin
      if (legal) begin
        cl3_d = (mode_i[F_CL_LO +: 3] == 3'd3);
        msk_d = bl_mask(mode_i[F_BL_LO +: 3]);
        wbm_d = mode_i[F_WBM];
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl3_q <= 1'b0;
      msk_q <= '0;
      wbm_q <= 1'b0;
      err_q <= 1'b0;
    end else if (load_i) begin
      cl3_q <= cl3_d;
      msk_q <= msk_d;
      wbm_q <= wbm_d;
      err_q <= err_d;
    end
  end

  assign cl3_o     = cl3_q;
  assign bl_mask_o = msk_q;
  assign wbm_o     = wbm_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sdseq_burst_gen.sv
module sdseq_burst_gen
  import sdseq_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [CNT_W-1:0] bl_mask_i,
  input  logic             wbm_i,
  output logic             cur_act_o,
  output logic             cur_wr_o,
  output logic [COL_W-1:0] cur_col_o,
  output logic             beat_act_o,
  output logic [COL_W-1:0] beat_col_o
);
  logic [CNT_W-1:0] left_q, left_d;
  logic [COL_W-1:0] nxt_q, nxt_d;
  logic [CNT_W-1:0] msk_q, cur_msk;
  logic             wr_q;
  logic             act, wr;
  logic [COL_W-1:0] col, mskw;
  logic             is_rd, is_wr;
  logic             beat_act_q;
  logic [COL_W-1:0] beat_col_q;

  always_comb begin
    is_rd = (cmd_i == CMD_READ);
    is_wr = (cmd_i == CMD_WRITE);
    if (is_rd || is_wr) begin
      act     = 1'b1;
      wr      = is_wr;
      col     = col_i;
      cur_msk = (is_wr && wbm_i) ? '0 : bl_mask_i;
      left_d  = cur_msk;
    end else if (left_q != '0) begin
      act     = 1'b1;
      wr      = wr_q;
      col     = nxt_q;
      cur_msk = msk_q;
      left_d  = left_q - CNT_W'(1);
    end else begin
      act     = 1'b0;
      wr      = 1'b0;
      col     = nxt_q;
      cur_msk = msk_q;
      left_d  = '0;
    end
    mskw  = COL_W'(cur_msk);
    nxt_d = (col & ~mskw) | ((col + COL_W'(1)) & mskw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q     <= '0;
      nxt_q      <= '0;
      msk_q      <= '0;
      wr_q       <= 1'b0;
      beat_act_q <= 1'b0;
      beat_col_q <= '0;
    end else begin
      beat_act_q <= act;
      if (act) begin
        left_q     <= left_d;
        nxt_q      <= nxt_d;
        msk_q      <= cur_msk;
        wr_q       <= wr;
        beat_col_q <= col;
      end
    end
  end

  assign cur_act_o  = act;
  assign cur_wr_o   = wr;
  assign cur_col_o  = col;
  assign beat_act_o = beat_act_q;
  assign beat_col_o = beat_col_q;
endmodule

// File: rtl/sdseq_rd_pipe.sv
module sdseq_rd_pipe
  import sdseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = CL_MAX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              cl3_i,
  output logic              oe_o,
  output logic              vld_o,
  output logic [DATA_W-1:0] dout_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [IDX_W-1:0]  tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-2:0], push_i};
    end
  end

  // data stages carry no reset, each loads only when its feeder is valid
  always_ff @(posedge clk) begin
    if (push_i) dat_q[0] <= din_i;
    for (int i = 1; i < DEPTH; i++) begin
      if (vld_q[i-1]) dat_q[i] <= dat_q[i-1];
    end
  end

  assign tap    = IDX_W'(CL_MIN) + IDX_W'(cl3_i);
  assign vld_o  = vld_q[tap];
  assign oe_o   = vld_q[tap] | vld_q[tap - IDX_W'(1)];
  assign dout_o = vld_q[tap] ? dat_q[tap] : '0;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdseq_pkg::*;
#(
  parameter int COL_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              dq_valid_o,
  output logic              beat_act_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic              mode_err_o
);
  localparam int WORDS = 1 << COL_W;

  logic             mode_cl3;
  logic             mode_wbm;
  logic [CNT_W-1:0] mode_msk;
  logic             cur_act, cur_wr;
  logic [COL_W-1:0] cur_col;
  logic [DATA_W-1:0] mem_q [WORDS];

  sdseq_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cmd_i == CMD_LOAD),
    .mode_i    (mode_i),
    .cl3_o     (mode_cl3),
    .bl_mask_o (mode_msk),
    .wbm_o     (mode_wbm),
    .err_o     (mode_err_o)
  );

  sdseq_burst_gen #(.COL_W(COL_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .col_i      (col_i),
    .bl_mask_i  (mode_msk),
    .wbm_i      (mode_wbm),
    .cur_act_o  (cur_act),
    .cur_wr_o   (cur_wr),
    .cur_col_o  (cur_col),
    .beat_act_o (beat_act_o),
    .beat_col_o (beat_col_o)
  );

  always_ff @(posedge clk) begin
    if (cur_act && cur_wr) mem_q[cur_col] <= wdata_i;
  end

  sdseq_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (cur_act && !cur_wr),
    .din_i  (mem_q[cur_col]),
    .cl3_i  (mode_cl3),
    .oe_o   (dq_oe_o),
    .vld_o  (dq_valid_o),
    .dout_o (dq_o)
  );
endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk
  import sdseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_i,
  input logic       dq_oe_o,
  input logic       dq_valid_o,
  input logic       beat_act_o,
  input logic       mode_err_o,
  input logic       cl3_i,
  input logic       wbm_i
);
  // R3: the enable is already up in the cycle before valid data starts
  p_oe_leads_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid_o) |-> $past(dq_oe_o));

  // R9: valid data never appears without the enable
  p_valid_within_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid_o |-> dq_oe_o);

  // R2: latency of two
  p_read_lat2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_READ && !cl3_i) |-> ##2 dq_oe_o ##1 dq_valid_o);

  // R2: latency of three
  p_read_lat3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_READ && cl3_i) |-> ##3 dq_oe_o ##1 dq_valid_o);

  // R8: the rejection flag holds until reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |=> mode_err_o);

  // R7: single-location write leaves no second beat
  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WRITE && wbm_i) ##1 (cmd_i == CMD_NOP) |=> !beat_act_o);
endmodule

bind sdr_burst_seq sdr_burst_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .dq_oe_o    (dq_oe_o),
  .dq_valid_o (dq_valid_o),
  .beat_act_o (beat_act_o),
  .mode_err_o (mode_err_o),
  .cl3_i      (mode_cl3),
  .wbm_i      (mode_wbm)
);

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 5;
  localparam int DATA_W     = 16;
  localparam int WORDS      = 1 << COL_W;
  localparam int WD_CYCLES  = 20000;

  localparam logic [1:0] C_NOP   = 2'b00;
  localparam logic [1:0] C_READ  = 2'b01;
  localparam logic [1:0] C_WRITE = 2'b10;
  localparam logic [1:0] C_LOAD  = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        cmd;
  logic [COL_W-1:0]  col;
  logic [9:0]        mode;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] dq;
  logic              dq_oe, dq_valid, beat_act, mode_err;
  logic [COL_W-1:0]  beat_col;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  int cl_m, bl_m;
  bit wbm_m, err_m;
  logic [DATA_W-1:0] ref_mem [WORDS];
  int junk = 3;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_burst_seq #(.COL_W(COL_W), .DATA_W(DATA_W)) i_sdr_burst_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .col_i      (col),
    .mode_i     (mode),
    .wdata_i    (wdata),
    .dq_o       (dq),
    .dq_oe_o    (dq_oe),
    .dq_valid_o (dq_valid),
    .beat_act_o (beat_act),
    .beat_col_o (beat_col),
    .mode_err_o (mode_err)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ecol(int c, int bl, int k);
    return (c & ~(bl - 1)) | ((c + k) & (bl - 1));
  endfunction

  function automatic logic [9:0] mk_mode(bit wbm, logic [1:0] op, logic [2:0] clc, logic [2:0] blc);
    return {wbm, op, clc, 1'b0, blc};
  endfunction

  // NOP with meaningless column and mode (R10)
  task automatic drive_nop(logic [DATA_W-1:0] wd);
    junk  = (junk * 13 + 7) & 1023;
    cmd   = C_NOP;
    col   = COL_W'(junk);
    mode  = 10'(junk ^ 10'h3F0);
    wdata = wd;
  endtask

  task automatic do_load(logic [9:0] m);
    cmd  = C_LOAD;
    mode = m;
    col  = '0;
    @(negedge clk);
    drive_nop('0);
    if ((m[6:4] == 3'd2 || m[6:4] == 3'd3) && m[8:7] == 2'b00) begin
      cl_m  = int'(m[6:4]);
      bl_m  = (m[2:0] < 3'd4) ? (1 << m[2:0]) : 1;
      wbm_m = m[9];
    end else begin
      err_m = 1'b1;
    end
    check(mode_err == err_m, "R8", "mode_err_o after load", int'(mode_err), int'(err_m));
  endtask

  task automatic do_write(int c, logic [DATA_W-1:0] base, string req);
    int blw = wbm_m ? 1 : bl_m;
    cmd   = C_WRITE;
    col   = COL_W'(c);
    wdata = base;
    for (int t = 0; t <= bl_m; t++) begin
      @(negedge clk);
      check(beat_act == (t < blw), req, "beat_act_o during write", int'(beat_act), int'(t < blw));
      if (t < blw)
        check(beat_col == COL_W'(ecol(c, blw, t)), "R5", "beat_col_o during write",
              int'(beat_col), ecol(c, blw, t));
      drive_nop(base + DATA_W'(t + 1));
    end
    for (int k = 0; k < blw; k++) ref_mem[ecol(c, blw, k)] = base + DATA_W'(k);
  endtask

  task automatic do_read(int c);
    cmd = C_READ;
    col = COL_W'(c);
    for (int t = 0; t <= cl_m + bl_m; t++) begin
      @(negedge clk);
      drive_nop('0);
      begin
        bit e_oe = (t >= cl_m - 1) && (t <= cl_m + bl_m - 1);
        bit e_v  = (t >= cl_m) && (t <= cl_m + bl_m - 1);
        int e_d  = e_v ? int'(ref_mem[ecol(c, bl_m, t - cl_m)]) : 0;
        string vt = (t == cl_m) ? "R2" : ((t == cl_m + bl_m) ? "R9" : "R4");
        check(dq_oe == e_oe, (t == cl_m + bl_m) ? "R9" : "R3", "dq_oe_o", int'(dq_oe), int'(e_oe));
        check(dq_valid == e_v, vt, "dq_valid_o", int'(dq_valid), int'(e_v));
        check(int'(dq) == e_d, "R5", "dq_o", int'(dq), e_d);
      end
    end
  endtask

  task automatic do_b2b(int c1, int c2);
    cmd = C_READ;
    col = COL_W'(c1);
    for (int t = 0; t <= cl_m + 2 * bl_m; t++) begin
      @(negedge clk);
      if (t == bl_m - 1) begin
        cmd = C_READ;
        col = COL_W'(c2);
      end else begin
        drive_nop('0);
      end
      begin
        bit e_oe = (t >= cl_m - 1) && (t <= cl_m + 2 * bl_m - 1);
        bit e_v  = (t >= cl_m) && (t <= cl_m + 2 * bl_m - 1);
        int k    = t - cl_m;
        int e_d  = !e_v ? 0 :
                   (k < bl_m) ? int'(ref_mem[ecol(c1, bl_m, k)]) : int'(ref_mem[ecol(c2, bl_m, k - bl_m)]);
        check(dq_oe == e_oe, "R9", "dq_oe_o back-to-back", int'(dq_oe), int'(e_oe));
        check(dq_valid == e_v, "R9", "dq_valid_o back-to-back", int'(dq_valid), int'(e_v));
        check(int'(dq) == e_d, "R9", "dq_o back-to-back", int'(dq), e_d);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive_nop('0);
    repeat (3) @(negedge clk);
    check(!dq_oe && !dq_valid, "R1", "bus in reset", int'({dq_oe, dq_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dq_oe && !dq_valid && !beat_act, "R1", "bus after reset",
          int'({dq_oe, dq_valid, beat_act}), 0);
    check(!mode_err, "R1", "mode_err_o after reset", int'(mode_err), 0);
    check(dq == '0, "R1", "dq_o after reset", int'(dq), 0);
    cl_m = 2; bl_m = 1; wbm_m = 1'b0; err_m = 1'b0;
    do_write(5, 16'hA5A5, "R1");
    do_read(5);
  endtask

  task automatic t_fill();
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd3));
    for (int b = 0; b < WORDS; b += 8) do_write(b + 3, DATA_W'(16'h1000 + b * 16), "R6");
    do_read(0);
  endtask

  task automatic t_cl2_bl4();
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd2));
    do_read(6);
    do_read(25);
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd1));
    do_read(11);
  endtask

  task automatic t_cl3_bl8();
    do_load(mk_mode(1'b0, 2'b00, 3'd3, 3'd3));
    do_read(13);
  endtask

  task automatic t_bl_reserved();
    do_load(mk_mode(1'b0, 2'b00, 3'd3, 3'd5));
    do_read(9);
    do_load({1'b0, 2'b00, 3'd2, 1'b1, 3'd7});
    do_read(30);
  endtask

  task automatic t_write_modes();
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd2));
    do_write(22, 16'h7700, "R6");
    do_read(20);
    do_load(mk_mode(1'b1, 2'b00, 3'd2, 3'd2));
    do_write(18, 16'hBE00, "R7");
    do_read(17);
  endtask

  task automatic t_b2b();
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd2));
    do_b2b(3, 21);
    do_load(mk_mode(1'b0, 2'b00, 3'd3, 3'd1));
    do_b2b(14, 7);
  endtask

  task automatic t_reject();
    do_load(mk_mode(1'b0, 2'b00, 3'd3, 3'd1));
    check(!mode_err, "R8", "no error after legal loads", int'(mode_err), 0);
    do_load(mk_mode(1'b0, 2'b00, 3'd1, 3'd3));
    do_read(3);
    do_load(mk_mode(1'b0, 2'b01, 3'd2, 3'd2));
    do_read(12);
    do_load(mk_mode(1'b0, 2'b00, 3'd2, 3'd0));
    do_read(5);
    check(mode_err, "R8", "mode_err_o sticky", int'(mode_err), 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_cl2_bl4();
    t_cl3_bl8();
    t_bl_reserved();
    t_write_modes();
    t_b2b();
    t_reject();
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", WD_CYCLES, 0);
      finish_run();
    end
  end
endmodule